// File: doc/BRIEF.md
# Six-step commutation controller

This block turns three Hall-sensor bits into gate enables for a three-phase bridge. The bridge has three outputs, and each output has a high-side switch and a low-side switch. For each valid Hall state the block turns on one high-side switch, which sources current into the winding, and one low-side switch, which sinks it. The high side stays on for the whole commutation step. Speed control chops only the low side.

Several gates act on the low side only:
- an active-low pulse input;
- an internal duty enable;
- an undervoltage flag;
- a current-limit trip, which is held until the next PWM period strobe.

The oscillator appears only as that one-clock period strobe. Stop mode, an over-temperature flag and a change of direction force all six enables off. A direction change is held pending behind a drive-off window of programmable length, so that the new direction never meets the old one inside a bridge leg.

The Hall bits pass through a synchronizer before they are decoded. All six enables leave the block from registers.

Top module: `bldc_commutator`

## Requirements
- R1: With the applied direction forward, the Hall code on `hall_raw` (bit 2 = sensor A, bit 1 = sensor B, bit 0 = sensor C) maps to high side / low side as follows. Bit 0 of `hi_en` and `lo_en` is phase U, bit 1 is phase V and bit 2 is phase W.
  - 101: V / U
  - 100: W / U
  - 110: W / V
  - 010: U / V
  - 011: U / W
  - 001: V / W
- R2: With the applied direction reverse, each of the R1 source/sink pairs is selected by the bitwise complement of its R1 code.
- R3: Hall codes 000 and 111 turn all six enables off.
- R4: `stop` high or `ot_flag` high turns all six enables off from the next clock edge.
- R5: `uv_flag` high turns all three low-side enables off from the next clock edge. The high-side enable is unaffected.
- R6: A low-side enable may be on only when `pwm_n` is low and `pwm_en` is high. The high-side enable is unaffected by either.
- R7: A clock edge with `ilim_trip` high turns the low side off. The low side stays off until the clock after the next edge on which `period_stb` is high and `ilim_trip` is low. A trip that coincides with a strobe is retained.
- R8: A change of `dir_rev` forces all six enables off for exactly DEAD_CYCLES clocks. On the following clock the outputs follow the new direction. `dir_rev` low means forward and high means reverse.
- R9: The high-side and low-side enables of one phase are never on together. At most one high-side enable and at most one low-side enable are on at a time.
- R10: A Hall change reaches the outputs on the third clock edge after it is applied: two synchronizer stages plus the output register.
- R11: While `rst_n` is low, all six enables are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hall_raw | input | 3 | Unsynchronized Hall bits {A,B,C} |
| dir_rev | input | 1 | Direction request: 0 forward, 1 reverse |
| stop | input | 1 | 1 stops the motor, 0 runs it |
| pwm_n | input | 1 | Pulse-input PWM, drive allowed when low |
| pwm_en | input | 1 | Internal PWM enable, drive allowed when high |
| period_stb | input | 1 | One-clock strobe at each PWM period start |
| ilim_trip | input | 1 | Current-limit comparator trip |
| uv_flag | input | 1 | Undervoltage detected |
| ot_flag | input | 1 | Over-temperature detected |
| hi_en | output | 3 | High-side enables {W,V,U} |
| lo_en | output | 3 | Low-side enables {W,V,U} |

## Verification
The current-limit trip and the period strobe can arrive in the same cycle. The bench drives both high together. It checks that the low side stays off through that strobe and also through the clock after it. It then checks that only a later strobe, with no trip present, lets the low side back on. A direction change can also overlap a running commutation step. The bench checks every clock of the drive-off window and then the first clock with the new pair.

// File: rtl/bldc_pkg.sv
package bldc_pkg;

   localparam int PHASES = 3;

   typedef struct packed {
      logic [PHASES-1:0] hi;
      logic [PHASES-1:0] lo;
   } drive_t;

   // Forward table; a reverse request complements the code first.
   function automatic drive_t bldc_decode(input logic [2:0] code, input logic rev);
      logic [2:0] k;
      drive_t d;
      k = rev ? ~code : code;
      d = '0;
      case (k)
         3'b101: begin d.hi = 3'b010; d.lo = 3'b001; end
         3'b100: begin d.hi = 3'b100; d.lo = 3'b001; end
         3'b110: begin d.hi = 3'b100; d.lo = 3'b010; end
         3'b010: begin d.hi = 3'b001; d.lo = 3'b010; end
         3'b011: begin d.hi = 3'b001; d.lo = 3'b100; end
         3'b001: begin d.hi = 3'b010; d.lo = 3'b100; end
         default: d = '0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/bldc_hall_sync.sv
module bldc_hall_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("bldc_hall_sync: STAGES must be at least 2");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[g] <= '0;
            else if (g == 0) st[g] <= d;
            else st[g] <= st[(g == 0) ? 0 : g-1];
         end
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/bldc_dir_guard.sv
module bldc_dir_guard #(
   parameter int DEAD = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_req,
   output logic dir_app,
   output logic blank
);
   localparam int CW = (DEAD < 2) ? 1 : $clog2(DEAD);
   localparam logic [CW-1:0] LAST = CW'(DEAD-1);

   logic [CW-1:0] cnt;

   generate
      if (DEAD < 1) begin : g_bad
         $error("bldc_dir_guard: DEAD must be at least 1");
      end
   endgenerate

   assign blank = dir_req != dir_app;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_app <= 1'b0;
         cnt     <= '0;
      end else if (!blank) begin
         cnt <= '0;
      end else if (cnt == LAST) begin
         dir_app <= dir_req;
         cnt     <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/bldc_ilim_chop.sv
module bldc_ilim_chop (
   input  logic clk,
   input  logic rst_n,
   input  logic trip,
   input  logic period_stb,
   output logic cut
);
   logic cut_q;

   // A trip wins over a strobe in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cut_q <= 1'b0;
      else if (trip) cut_q <= 1'b1;
      else if (period_stb) cut_q <= 1'b0;
   end

   assign cut = trip | cut_q;
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
   import bldc_pkg::*;
#(
   parameter int DEAD_CYCLES = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        hall_raw,
   input  logic              dir_rev,
   input  logic              stop,
   input  logic              pwm_n,
   input  logic              pwm_en,
   input  logic              period_stb,
   input  logic              ilim_trip,
   input  logic              uv_flag,
   input  logic              ot_flag,
   output logic [PHASES-1:0] hi_en,
   output logic [PHASES-1:0] lo_en
);
   logic [2:0] hall_s;
   logic       dir_app;
   logic       blank;
   logic       cut;
   drive_t     drv;
   logic       kill_all;
   logic       lo_ok;

   bldc_hall_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(hall_raw), .q(hall_s)
   );

   bldc_dir_guard #(.DEAD(DEAD_CYCLES)) u_dir (
      .clk(clk), .rst_n(rst_n), .dir_req(dir_rev), .dir_app(dir_app), .blank(blank)
   );

   bldc_ilim_chop u_chop (
      .clk(clk), .rst_n(rst_n), .trip(ilim_trip), .period_stb(period_stb), .cut(cut)
   );

   always_comb begin
      drv      = bldc_decode(hall_s, dir_app);
      kill_all = stop | ot_flag | blank;
      lo_ok    = ~uv_flag & ~pwm_n & pwm_en & ~cut;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_en <= '0;
         lo_en <= '0;
      end else begin
         hi_en <= kill_all ? '0 : drv.hi;
         lo_en <= (kill_all | ~lo_ok) ? '0 : drv.lo;
      end
   end
endmodule

// File: rtl/bldc_commutator_chk.sv
module bldc_commutator_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] hall_s,
   input logic       dir_rev,
   input logic       dir_app,
   input logic       stop,
   input logic       pwm_n,
   input logic       pwm_en,
   input logic       ilim_trip,
   input logic       uv_flag,
   input logic       ot_flag,
   input logic [2:0] hi_en,
   input logic [2:0] lo_en
);
   p_phase_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_en & lo_en) == 3'b000);

   p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hi_en) && $onehot0(lo_en));

   p_stop_ot_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stop || ot_flag) |=> (hi_en == 3'b000 && lo_en == 3'b000));

   p_uv_lo_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      uv_flag |=> (lo_en == 3'b000));

   p_pwm_lo_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_n || !pwm_en) |=> (lo_en == 3'b000));

   p_ilim_lo_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ilim_trip |=> (lo_en == 3'b000));

   p_dir_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_rev != dir_app) |=> (hi_en == 3'b000 && lo_en == 3'b000));

   p_bad_hall_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hall_s == 3'b000 || hall_s == 3'b111) |=> (hi_en == 3'b000 && lo_en == 3'b000));
endmodule

bind bldc_commutator bldc_commutator_chk u_chk (
   .clk(clk), .rst_n(rst_n), .hall_s(hall_s), .dir_rev(dir_rev), .dir_app(dir_app),
   .stop(stop), .pwm_n(pwm_n), .pwm_en(pwm_en), .ilim_trip(ilim_trip),
   .uv_flag(uv_flag), .ot_flag(ot_flag), .hi_en(hi_en), .lo_en(lo_en)
);

// File: tb/bldc_commutator_bench.sv
module bldc_commutator_bench;
   localparam int PERIOD = 10;
   localparam int DEAD   = 8;

   // {dir, hall[2:0], exp_hi[2:0], exp_lo[2:0]}
   localparam logic [9:0] VEC [16] = '{
      10'b0_101_010_001, 10'b0_100_100_001, 10'b0_110_100_010, 10'b0_010_001_010,
      10'b0_011_001_100, 10'b0_001_010_100, 10'b0_000_000_000, 10'b0_111_000_000,
      10'b1_010_010_001, 10'b1_011_100_001, 10'b1_001_100_010, 10'b1_101_001_010,
      10'b1_100_001_100, 10'b1_110_010_100, 10'b1_000_000_000, 10'b1_111_000_000
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] hall_raw = 3'b000;
   logic       dir_rev = 1'b0, stop = 1'b0, pwm_n = 1'b0, pwm_en = 1'b1;
   logic       period_stb = 1'b0, ilim_trip = 1'b0, uv_flag = 1'b0, ot_flag = 1'b0;
   logic [2:0] hi_en, lo_en;
   int         n_chk = 0;
   int         n_bad = 0;

   always #(PERIOD/2) clk = ~clk;

   bldc_commutator #(.DEAD_CYCLES(DEAD), .SYNC_STAGES(2)) u_bldc_commutator (
      .clk(clk), .rst_n(rst_n), .hall_raw(hall_raw), .dir_rev(dir_rev), .stop(stop),
      .pwm_n(pwm_n), .pwm_en(pwm_en), .period_stb(period_stb), .ilim_trip(ilim_trip),
      .uv_flag(uv_flag), .ot_flag(ot_flag), .hi_en(hi_en), .lo_en(lo_en)
   );

   task automatic check(input string req, input logic [2:0] eh, input logic [2:0] el);
      n_chk++;
      if (hi_en !== eh || lo_en !== el) begin
         n_bad++;
         $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", req, hi_en, lo_en, eh, el);
      end
   endtask

   task automatic edge_sample();
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(PERIOD*100000);
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      hall_raw = 3'b101;
      repeat (4) edge_sample();
      check("R11 reset", 3'b000, 3'b000);
      @(negedge clk) rst_n = 1'b1;

      // Table walk: R1 forward, R2 reverse, R3 invalid codes
      foreach (VEC[i]) begin
         @(negedge clk);
         dir_rev  = VEC[i][9];
         hall_raw = VEC[i][8:6];
         repeat (DEAD + 4) edge_sample();
         check(VEC[i][9] ? (VEC[i][5:0] == 0 ? "R3 reverse" : "R2 reverse")
                         : (VEC[i][5:0] == 0 ? "R3 forward" : "R1 forward"),
               VEC[i][5:3], VEC[i][2:0]);
      end

      // Back to forward, code 101 -> V high, U low
      @(negedge clk); dir_rev = 1'b0; hall_raw = 3'b101;
      repeat (DEAD + 4) edge_sample();
      check("R1 setup", 3'b010, 3'b001);

      // R10: Hall latency of three edges
      @(negedge clk) hall_raw = 3'b100;
      edge_sample(); edge_sample();
      check("R10 old value held", 3'b010, 3'b001);
      edge_sample();
      check("R10 new value", 3'b100, 3'b001);

      // R4 stop and over-temperature
      @(negedge clk) stop = 1'b1;
      edge_sample();
      check("R4 stop", 3'b000, 3'b000);
      @(negedge clk) begin stop = 1'b0; ot_flag = 1'b1; end
      edge_sample();
      check("R4 over-temp", 3'b000, 3'b000);
      @(negedge clk) ot_flag = 1'b0;
      edge_sample();
      check("R4 release", 3'b100, 3'b001);

      // R5 undervoltage
      @(negedge clk) uv_flag = 1'b1;
      edge_sample();
      check("R5 undervoltage", 3'b100, 3'b000);
      @(negedge clk) uv_flag = 1'b0;

      // R6 pulse input and internal enable
      @(negedge clk) pwm_n = 1'b1;
      edge_sample();
      check("R6 pulse input high", 3'b100, 3'b000);
      @(negedge clk) begin pwm_n = 1'b0; pwm_en = 1'b0; end
      edge_sample();
      check("R6 enable low", 3'b100, 3'b000);
      @(negedge clk) pwm_en = 1'b1;
      edge_sample();
      check("R6 restored", 3'b100, 3'b001);

      // R7 current limit held until next strobe
      @(negedge clk) ilim_trip = 1'b1;
      edge_sample();
      check("R7 trip", 3'b100, 3'b000);
      @(negedge clk) ilim_trip = 1'b0;
      edge_sample();
      check("R7 held after trip", 3'b100, 3'b000);
      @(negedge clk) period_stb = 1'b1;
      edge_sample();
      check("R7 strobe edge", 3'b100, 3'b000);
      @(negedge clk) period_stb = 1'b0;
      edge_sample();
      check("R7 released", 3'b100, 3'b001);

      // R7 trip and strobe together: trip retained
      @(negedge clk) begin ilim_trip = 1'b1; period_stb = 1'b1; end
      edge_sample();
      check("R7 coincident", 3'b100, 3'b000);
      @(negedge clk) begin ilim_trip = 1'b0; period_stb = 1'b0; end
      edge_sample();
      check("R7 coincident retained", 3'b100, 3'b000);
      @(negedge clk) period_stb = 1'b1;
      edge_sample();
      @(negedge clk) period_stb = 1'b0;
      edge_sample();
      check("R7 later strobe releases", 3'b100, 3'b001);

      // R8 direction change window; code 100 reverse -> U high, W low
      @(negedge clk) dir_rev = 1'b1;
      for (int k = 0; k < DEAD; k++) begin
         edge_sample();
         check("R8 drive-off window", 3'b000, 3'b000);
      end
      edge_sample();
      check("R8 new direction", 3'b001, 3'b100);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule